// File: doc/BRIEF.md
# Nibble Add-With-Carry Executor

This block carries out the add-with-carry instruction group of a small 4-bit accumulator core. Each accepted opcode names a destination accumulator (A or B) and an index register (X or Y). The block fetches one 4-bit operand from data memory through a synchronous read port. It adds that operand and the carry flag to the destination, then writes back the sum together with the carry and zero flags. The incrementing variants advance the chosen index register by one.

A separate prefix input arms a one-shot extension with an 8-bit offset. While the extension is armed, the non-incrementing forms do not use the index register. They read from a fixed page instead: the low page for X and the top page for Y. The incrementing forms ignore the extension. The extension disarms after the next instruction of any kind. Instructions can issue on every clock. The index update and the memory address belong to the issue cycle, and the accumulator and flags are written one clock later, when the memory data returns.

Top module: `nib_adc_unit`

## Requirements
- R1: A synchronous active-high reset clears A, B, the carry, zero and extension flags and the latched offset, and loads X and Y with the parameters IDX_RST_X and IDX_RST_Y (both 0 by default).
- R2: An opcode is recognised when instr_op[12:3] equals 0x33C (range 0x19E0 to 0x19E7). Bit 0 selects the incrementing form, bit 1 selects Y rather than X, and bit 2 selects B rather than A. Any other opcode leaves A, B, X, Y, carry and zero unchanged and raises no memory read.
- R3: In the cycle a recognised opcode is presented with instr_valid high, mem_rd is high and mem_addr carries the selected index register (unless R8 applies). The memory returns the operand on mem_rdata one clock later.
- R4: At the clock edge after the issue edge, the destination takes (dest + operand + carry) mod 16, and the carry flag takes the carry out of bit 3 of that sum.
- R5: At the same edge the zero flag is set exactly when the 4-bit result is 0.
- R6: An incrementing form adds one to its index register at the issue edge, wrapping from FFFFH to 0000H. Carry and zero come only from the addition.
- R7: pfx_valid sets the extension flag and latches pfx_imm. Any instr_valid cycle without pfx_valid clears the flag at that edge, whatever the opcode.
- R8: With the extension flag set, a non-incrementing X form reads address 00H:offset and a Y form reads FFH:offset, and neither index register changes.
- R9: With the extension flag set, an incrementing form still reads from its index register and still increments it.
- R10: Instructions may issue on consecutive cycles. Each one uses the accumulator and carry left by the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr_op | input | 13 | Instruction opcode |
| pfx_valid | input | 1 | Extension prefix presented this cycle |
| pfx_imm | input | 8 | Page offset carried by the prefix |
| mem_rd | output | 1 | Data memory read strobe |
| mem_addr | output | 16 | Data memory address |
| mem_rdata | input | 4 | Operand returned one clock after mem_rd |
| reg_a | output | 4 | Accumulator A |
| reg_b | output | 4 | Accumulator B |
| reg_x | output | 16 | Index register X |
| reg_y | output | 16 | Index register Y |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| flag_e | output | 1 | Extension armed flag |

## Verification
mem_addr and mem_rd are combinational in the issue cycle, so the driver compares them 1 ns after it sets the opcode. The index registers and the extension flag are due one edge after issue. The accumulators and the carry and zero flags are due two edges after the cycle in which the opcode was driven, because the operand needs one memory clock. The driver therefore pushes two scoreboard entries per instruction, each stamped with the cycle it is due in. A monitor that samples between edges compares each entry in exactly that cycle. Because the entries are due in different cycles, an index update or accumulator write that comes one edge early or late shows up as a mismatch, even when instructions issue back to back.

// File: rtl/nadc_pkg.sv
package nadc_pkg;

  // Opcode selector bit positions inside the instruction group
  localparam int SEL_INC_BIT = 0;
  localparam int SEL_Y_BIT   = 1;
  localparam int SEL_B_BIT   = 2;
  localparam int SEL_BITS    = 3;

  typedef struct packed {
    logic hit;       // valid opcode of this group
    logic to_b;      // destination B
    logic use_y;     // index Y
    logic post_inc;  // incrementing form
  } adc_dec_t;

endpackage

// File: rtl/nadc_decode.sv
module nadc_decode
  import nadc_pkg::*;
#(
  parameter int              OP_W    = 13,
  parameter logic [OP_W-1:0] OP_BASE = 13'h19E0
) (
  input  logic            valid,
  input  logic [OP_W-1:0] op,
  output adc_dec_t        dec
);

  logic family_match;

  assign family_match = (op[OP_W-1:SEL_BITS] == OP_BASE[OP_W-1:SEL_BITS]);

  always_comb begin
    dec.hit      = valid & family_match;
    dec.post_inc = op[SEL_INC_BIT];
    dec.use_y    = op[SEL_Y_BIT];
    dec.to_b     = op[SEL_B_BIT];
  end

endmodule

// File: rtl/nadc_agen.sv
module nadc_agen
  import nadc_pkg::*;
#(
  parameter int AW = 16,
  parameter int IW = 8
) (
  input  adc_dec_t        dec,
  input  logic [AW-1:0]   idx_x,
  input  logic [AW-1:0]   idx_y,
  input  logic            ext_on,
  input  logic [IW-1:0]   ext_off,
  output logic [AW-1:0]   rd_addr,
  output logic [AW-1:0]   idx_next,
  output logic            ext_taken
);

  localparam int PAGE_W = AW - IW;

  // Fixed page address: all-ones page for Y, zero page for X
  function automatic logic [AW-1:0] page_addr(input logic hi_page,
                                              input logic [IW-1:0] off);
    return {{PAGE_W{hi_page}}, off};
  endfunction

  // Index step, wraps at the top of the address space
  function automatic logic [AW-1:0] step_index(input logic [AW-1:0] v);
    return v + AW'(1);
  endfunction

  logic [AW-1:0] idx_cur;

  assign idx_cur   = dec.use_y ? idx_y : idx_x;
  assign ext_taken = dec.hit & ext_on & ~dec.post_inc;
  assign rd_addr   = ext_taken ? page_addr(dec.use_y, ext_off) : idx_cur;
  assign idx_next  = step_index(idx_cur);

endmodule

// File: rtl/nadc_alu.sv
module nadc_alu #(
  parameter int DW = 4
) (
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] opnd,
  input  logic          cin,
  output logic [DW-1:0] sum,
  output logic          cout,
  output logic          zero
);

  function automatic logic [DW:0] add_carry(input logic [DW-1:0] a,
                                            input logic [DW-1:0] b,
                                            input logic          c);
    return {1'b0, a} + {1'b0, b} + (DW+1)'(c);
  endfunction

  assign {cout, sum} = add_carry(acc, opnd, cin);
  assign zero        = (sum == '0);

endmodule

// File: rtl/nib_adc_unit.sv
module nib_adc_unit
  import nadc_pkg::*;
#(
  parameter int            DW        = 4,
  parameter int            AW        = 16,
  parameter int            IW        = 8,
  parameter int            OP_W      = 13,
  parameter logic [OP_W-1:0] OP_BASE = 13'h19E0,
  parameter logic [AW-1:0] IDX_RST_X = '0,
  parameter logic [AW-1:0] IDX_RST_Y = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            instr_valid,
  input  logic [OP_W-1:0] instr_op,
  input  logic            pfx_valid,
  input  logic [IW-1:0]   pfx_imm,
  output logic            mem_rd,
  output logic [AW-1:0]   mem_addr,
  input  logic [DW-1:0]   mem_rdata,
  output logic [DW-1:0]   reg_a,
  output logic [DW-1:0]   reg_b,
  output logic [AW-1:0]   reg_x,
  output logic [AW-1:0]   reg_y,
  output logic            flag_c,
  output logic            flag_z,
  output logic            flag_e
);

  // ---------------- issue stage ----------------
  adc_dec_t      dec;
  logic [IW-1:0] ext_off_q;
  logic [AW-1:0] idx_next;
  logic          ext_taken;

  nadc_decode #(.OP_W(OP_W), .OP_BASE(OP_BASE)) u_dec (
    .valid (instr_valid),
    .op    (instr_op),
    .dec   (dec)
  );

  nadc_agen #(.AW(AW), .IW(IW)) u_agen (
    .dec       (dec),
    .idx_x     (reg_x),
    .idx_y     (reg_y),
    .ext_on    (flag_e),
    .ext_off   (ext_off_q),
    .rd_addr   (mem_addr),
    .idx_next  (idx_next),
    .ext_taken (ext_taken)
  );

  // Named internal events
  logic issue_fire, issue_bump_x, issue_bump_y, exec_fire, ext_clear;
  assign issue_fire   = dec.hit;
  assign issue_bump_x = issue_fire & dec.post_inc & ~dec.use_y;
  assign issue_bump_y = issue_fire & dec.post_inc &  dec.use_y;
  assign ext_clear    = instr_valid & ~pfx_valid;
  assign mem_rd       = issue_fire;

  // ---------------- execute stage ----------------
  logic          ex_valid, ex_to_b;
  logic [DW-1:0] alu_acc, alu_sum;
  logic          alu_cout, alu_zero;

  assign exec_fire = ex_valid;
  assign alu_acc   = ex_to_b ? reg_b : reg_a;

  nadc_alu #(.DW(DW)) u_alu (
    .acc  (alu_acc),
    .opnd (mem_rdata),
    .cin  (flag_c),
    .sum  (alu_sum),
    .cout (alu_cout),
    .zero (alu_zero)
  );

  // ---------------- state ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_a     <= '0;
      reg_b     <= '0;
      reg_x     <= IDX_RST_X;
      reg_y     <= IDX_RST_Y;
      flag_c    <= 1'b0;
      flag_z    <= 1'b0;
      flag_e    <= 1'b0;
      ext_off_q <= '0;
      ex_valid  <= 1'b0;
      ex_to_b   <= 1'b0;
    end else begin
      if (issue_bump_x) reg_x <= idx_next;
      if (issue_bump_y) reg_y <= idx_next;
      ex_valid <= issue_fire;
      ex_to_b  <= dec.to_b;
      if (pfx_valid) begin
        flag_e    <= 1'b1;
        ext_off_q <= pfx_imm;
      end else if (ext_clear) begin
        flag_e <= 1'b0;
      end
      if (exec_fire) begin
        if (ex_to_b) reg_b <= alu_sum;
        else         reg_a <= alu_sum;
        flag_c <= alu_cout;
        flag_z <= alu_zero;
      end
    end
  end

  // ---------------- assertions ----------------
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (reg_a == '0 && reg_b == '0 && !flag_c && !flag_z && !flag_e &&
             reg_x == IDX_RST_X && reg_y == IDX_RST_Y));

  assert_index_step_x_R6: assert property (@(posedge clk) disable iff (rst)
    issue_bump_x |=> reg_x == $past(reg_x) + AW'(1));

  assert_index_step_y_R6: assert property (@(posedge clk) disable iff (rst)
    issue_bump_y |=> reg_y == $past(reg_y) + AW'(1));

  assert_index_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (issue_fire && !dec.post_inc) |=> ($stable(reg_x) && $stable(reg_y)));

  assert_ext_offset_R8: assert property (@(posedge clk) disable iff (rst)
    (issue_fire && flag_e && !dec.post_inc) |-> mem_addr[IW-1:0] == ext_off_q);

  assert_ext_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (issue_fire && dec.post_inc) |-> mem_addr == (dec.use_y ? reg_y : reg_x));

  assert_ext_clear_R7: assert property (@(posedge clk) disable iff (rst)
    ext_clear |=> !flag_e);

  assert_sum_carry_R4: assert property (@(posedge clk) disable iff (rst)
    exec_fire |=> {flag_c, ($past(ex_to_b) ? reg_b : reg_a)} ==
      (DW+1)'($past(alu_acc)) + (DW+1)'($past(mem_rdata)) + (DW+1)'($past(flag_c)));

  assert_zero_a_R5: assert property (@(posedge clk) disable iff (rst)
    (exec_fire && !ex_to_b) |=> flag_z == (reg_a == '0));

  assert_zero_b_R5: assert property (@(posedge clk) disable iff (rst)
    (exec_fire && ex_to_b) |=> flag_z == (reg_b == '0));

endmodule

// File: tb/nib_adc_unit_test.sv
module nib_adc_unit_test;

  localparam logic [15:0] X0 = 16'h0000;
  localparam logic [15:0] Y0 = 16'hFFFE;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [12:0] instr_op = '0;
  logic        pfx_valid = 1'b0;
  logic [7:0]  pfx_imm = '0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [3:0]  mem_rdata = '0;
  logic [3:0]  reg_a, reg_b;
  logic [15:0] reg_x, reg_y;
  logic        flag_c, flag_z, flag_e;

  always #4 clk = ~clk;  // 125 MHz

  nib_adc_unit #(.IDX_RST_X(X0), .IDX_RST_Y(Y0)) uut (
    .clk, .rst, .instr_valid, .instr_op, .pfx_valid, .pfx_imm,
    .mem_rd, .mem_addr, .mem_rdata,
    .reg_a, .reg_b, .reg_x, .reg_y, .flag_c, .flag_z, .flag_e
  );

  // Data memory model: synchronous read, contents derived from the address
  function automatic logic [3:0] mem_nib(input logic [15:0] a);
    return (a[3:0] ^ a[15:12]) + a[7:4];
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= mem_nib(mem_addr);

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // Scoreboard
  typedef struct {
    int          due;
    bit          acc;
    string       tag;
    logic [15:0] x, y;
    logic        e;
    logic [3:0]  a, b;
    logic        c, z;
  } exp_t;
  exp_t sbq[$];

  // Reference state
  logic [3:0]  m_a = '0, m_b = '0;
  logic [15:0] m_x = X0, m_y = Y0;
  logic        m_c = 0, m_z = 0, m_e = 0;
  logic [7:0]  m_imm = '0;

  task automatic push(input int due, input bit acc, input string tag);
    exp_t it;
    it.due = due; it.acc = acc; it.tag = tag;
    it.x = m_x; it.y = m_y; it.e = m_e;
    it.a = m_a; it.b = m_b; it.c = m_c; it.z = m_z;
    sbq.push_back(it);
  endtask

  // Monitor: compares entries in the cycle they are due
  always @(negedge clk) begin
    #2;
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      exp_t it;
      it = sbq.pop_front();
      if (it.acc) begin
        check(it.tag, "reg_a", reg_a, it.a);
        check(it.tag, "reg_b", reg_b, it.b);
        check(it.tag, "flag_c", flag_c, it.c);
        check(it.tag, "flag_z (R5)", flag_z, it.z);
      end else begin
        check(it.tag, "reg_x", reg_x, it.x);
        check(it.tag, "reg_y", reg_y, it.y);
        check(it.tag, "flag_e (R7)", flag_e, it.e);
      end
    end
  end

  // Driver: one instruction per call, back to back when called in a row
  task automatic issue(input logic [12:0] op, input string tag);
    bit          hit, inc, ysel, bsel;
    logic [15:0] addr;
    logic [3:0]  dat, acc;
    int          total;
    @(negedge clk);
    instr_valid = 1'b1; instr_op = op; pfx_valid = 1'b0;
    hit  = (op[12:3] == 10'h33C);
    inc  = op[0]; ysel = op[1]; bsel = op[2];
    #1;
    check(tag, "mem_rd (R3)", mem_rd, hit);
    if (hit) begin
      if (m_e && !inc) addr = ysel ? {8'hFF, m_imm} : {8'h00, m_imm};
      else             addr = ysel ? m_y : m_x;
      check(tag, "mem_addr", mem_addr, addr);
      dat   = mem_nib(addr);
      acc   = bsel ? m_b : m_a;
      total = int'(acc) + int'(dat) + int'(m_c);
      if (bsel) m_b = 4'(total % 16); else m_a = 4'(total % 16);
      m_c = (total > 15);
      m_z = ((total % 16) == 0);
      if (inc) begin
        if (ysel) m_y = (m_y == 16'hFFFF) ? 16'h0000 : m_y + 16'h1;
        else      m_x = (m_x == 16'hFFFF) ? 16'h0000 : m_x + 16'h1;
      end
    end
    m_e = 1'b0;
    push(cyc + 1, 1'b0, tag);
    push(cyc + 2, 1'b1, tag);
  endtask

  task automatic prefix(input logic [7:0] imm, input string tag);
    @(negedge clk);
    instr_valid = 1'b0; pfx_valid = 1'b1; pfx_imm = imm;
    m_e = 1'b1; m_imm = imm;
    push(cyc + 1, 1'b0, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      instr_valid = 1'b0; pfx_valid = 1'b0;
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    // R1: reset state
    check("R1", "reg_a", reg_a, 4'h0);
    check("R1", "reg_b", reg_b, 4'h0);
    check("R1", "reg_x", reg_x, X0);
    check("R1", "reg_y", reg_y, Y0);
    check("R1", "flags", {flag_c, flag_z, flag_e}, 3'b000);

    issue(13'h19E0, "R5");          // A + mem[0] + 0 = 0, zero set
    // R10: back-to-back with mixed destinations, R6 increments
    issue(13'h19E1, "R10");
    issue(13'h19E5, "R10");
    issue(13'h19E1, "R6");
    issue(13'h19E5, "R4");
    issue(13'h19E4, "R10");
    // R6: Y wraps FFFE -> FFFF -> 0000
    issue(13'h19E3, "R6");
    issue(13'h19E3, "R6");
    issue(13'h19E7, "R2");
    idle(1);
    // R8: extension redirects non-incrementing forms
    prefix(8'h3C, "R7");
    issue(13'h19E0, "R8");
    prefix(8'hA5, "R7");
    issue(13'h19E6, "R8");
    // R9: incrementing forms ignore the extension
    prefix(8'h11, "R7");
    issue(13'h19E1, "R9");
    prefix(8'h22, "R7");
    issue(13'h19E7, "R9");
    // R7: foreign opcode consumes the extension
    prefix(8'h44, "R7");
    idle(2);
    issue(13'h1234, "R7");
    issue(13'h19E0, "R7");
    // R2: neighbouring opcodes are not part of the group
    issue(13'h19E8, "R2");
    issue(13'h19DF, "R2");
    idle(2);
    // Mixed pseudo-random stream (R4, R10)
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[4:3] == 2'b00)      prefix(lfsr[15:8], "R7");
      else if (lfsr[7:5] == 3'b111) issue(lfsr[12:0], "R2");
      else                          issue({10'h33C, lfsr[2:0]}, "R4");
    end
    idle(4);
    while (sbq.size() > 0) @(negedge clk);
    #3;
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

endmodule